// File: doc/BRIEF.md
# Segment Effective Base Tracker

This block holds, for each of six data and code segments, two base values: the base that software last programmed and the effective base that address generation adds to an offset. Four of the segments (extra, code, stack and data) drop their bases in 64-bit code. Their effective bases read as zero while 64-bit code runs and return to their programmed values when it is left. The two remaining segments (the two general extra segments) always use their programmed bases.

The block takes three kinds of input. A base write names a segment and carries a value. A code-segment attribute write carries the new long-mode bit of the code segment. A level input reports whether long mode is active. The block presents all six effective bases at once on one packed output bus. Running in 64-bit code means that long mode is active and the stored code-segment long-mode bit is set.

Top module: `seg_base_tracker`

## Requirements
- R1: A base write to segment code 4 or 5 copies the value into that segment's effective base at the next clock edge, in every mode. Mode changes never alter those two effective bases.
- R2: A base write to segment code 0, 1, 2 or 3 updates that segment's effective base at the next edge only when long mode is inactive or the stored code-segment long-mode bit is clear. Otherwise the effective base keeps its value.
- R3: An attribute write that changes the stored long-mode bit from 0 to 1 clears effective bases 0 to 3 to zero. This happens whatever the long-mode-active input is.
- R4: An attribute write that changes the stored long-mode bit from 1 to 0 reloads each of effective bases 0 to 3 from its own programmed base.
- R5: An attribute write that repeats the stored long-mode bit leaves all effective bases unchanged.
- R6: Every base write stores its value as that segment's programmed base in every mode. This is seen when the value is later reloaded under R4.
- R7: Reset clears all programmed bases, all effective bases and the stored long-mode bit to zero.
- R8: When a base write and an attribute write arrive in the same cycle, the attribute write acts first. The base write is then judged against the new long-mode bit, so it can override a reload or be blocked after a clear.
- R9: A base write with segment code 6 or 7 changes nothing.
- R10: A change of the long-mode-active input alone leaves all effective bases unchanged.

Segment codes: 0 extra, 1 code, 2 stack, 3 data, 4 and 5 the two general extra segments. Segment k's effective base occupies bits [k*BASE_W +: BASE_W] of the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Base write strobe |
| base_wr_sel | input | 3 | Segment code of the base write |
| base_wr_data | input | BASE_W | Base value to write |
| attr_wr_en | input | 1 | Code-segment attribute write strobe |
| attr_wr_long | input | 1 | Long-mode bit carried by the attribute write |
| long_active | input | 1 | Long mode active |
| eff_base | output | 6*BASE_W | All effective bases, segment k in slice k |

## Verification
The assertions check the per-cycle rules inside each segment slot on every clock. These rules are: clearing on entry to 64-bit code, reloading from the programmed base on exit, holding without a cause, blocking gated writes, the always-follow rule of segments 4 and 5, storing the programmed base, and the stored long-mode bit tracking attribute writes. Only the bench's scenarios can show that a value written while 64-bit code blocks it comes back intact after exit. The same holds for the resolution of same-cycle collisions, the lack of effect of selector codes 6 and 7, and independence from the long-mode-active level when no write occurs.

// File: rtl/seg_base_pkg.sv
package seg_base_pkg;

   localparam int unsigned NUM_SEG = 6;
   localparam int unsigned SEL_W   = 3;

   typedef enum logic [SEL_W-1:0] {
      SEG_EXTRA   = 3'd0,
      SEG_CODE    = 3'd1,
      SEG_STACK   = 3'd2,
      SEG_DATA    = 3'd3,
      SEG_GEN_A   = 3'd4,
      SEG_GEN_B   = 3'd5
   } seg_id_e;

   // Segments at or above this code always use their programmed bases.
   localparam int unsigned FIRST_FOLLOW_SEG = 4;

   function automatic bit seg_follows_always(input int unsigned idx);
      return idx >= FIRST_FOLLOW_SEG;
   endfunction

endpackage

// File: rtl/seg_mode_ctrl.sv
module seg_mode_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic attr_wr_en,
   input  logic attr_wr_long,
   input  logic long_active,
   output logic enter64,
   output logic leave64,
   output logic gate64
);

   logic cs_long_q;
   logic cs_long_nxt;

   always_comb begin
      cs_long_nxt = cs_long_q;
      if (attr_wr_en) begin
         cs_long_nxt = attr_wr_long;
      end
   end

   // Toggle pulses act before any base write of the same cycle.
   assign enter64 = attr_wr_en &  attr_wr_long & ~cs_long_q;
   assign leave64 = attr_wr_en & ~attr_wr_long &  cs_long_q;
   assign gate64  = long_active & cs_long_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_long_q <= 1'b0;
      end else begin
         cs_long_q <= cs_long_nxt;
      end
   end

   assert_toggle_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({enter64, leave64}));

   assert_long_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
      attr_wr_en |=> (cs_long_q == $past(attr_wr_long)));

   assert_long_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !attr_wr_en |=> $stable(cs_long_q));

endmodule

// File: rtl/seg_base_slot.sv
module seg_base_slot #(
   parameter int unsigned BASE_W = 64,
   parameter bit          FOLLOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [BASE_W-1:0] wr_data,
   input  logic              enter64,
   input  logic              leave64,
   input  logic              gate64,
   output logic [BASE_W-1:0] eff_q
);

   logic [BASE_W-1:0] prog_q;
   logic [BASE_W-1:0] eff_nxt;

   if (BASE_W < 1) begin : g_bad_width
      $error("seg_base_slot: BASE_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_q <= '0;
      end else if (wr_hit) begin
         prog_q <= wr_data;
      end
   end

   if (FOLLOW) begin : g_follow
      always_comb begin
         eff_nxt = eff_q;
         if (wr_hit) begin
            eff_nxt = wr_data;
         end
      end

      assert_follow_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
         wr_hit |=> (eff_q == $past(wr_data)));

      assert_follow_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
         ((enter64 || leave64 || gate64) && !wr_hit) |=> $stable(eff_q));

      assert_follow_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
         eff_q == prog_q);
   end else begin : g_suppress
      always_comb begin
         eff_nxt = eff_q;
         if (enter64) begin
            eff_nxt = '0;
         end else if (leave64) begin
            eff_nxt = prog_q;
         end
         if (wr_hit && !gate64) begin
            eff_nxt = wr_data;
         end
      end

      assert_enter_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (enter64 && !(wr_hit && !gate64)) |=> (eff_q == '0));

      assert_leave_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (leave64 && !wr_hit) |=> (eff_q == $past(prog_q)));

      assert_open_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && !gate64) |=> (eff_q == $past(wr_data)));

      assert_gated_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && gate64 && !enter64 && !leave64) |=> $stable(eff_q));

      assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_hit && !enter64 && !leave64) |=> $stable(eff_q));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eff_q <= '0;
      end else begin
         eff_q <= eff_nxt;
      end
   end

   assert_prog_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (prog_q == $past(wr_data)));

   assert_prog_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(prog_q));

endmodule

// File: rtl/seg_base_tracker.sv
module seg_base_tracker
   import seg_base_pkg::*;
#(
   parameter int unsigned BASE_W = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        base_wr_en,
   input  logic [2:0]                  base_wr_sel,
   input  logic [BASE_W-1:0]           base_wr_data,
   input  logic                        attr_wr_en,
   input  logic                        attr_wr_long,
   input  logic                        long_active,
   output logic [NUM_SEG*BASE_W-1:0]   eff_base
);

   localparam int unsigned BUS_W = NUM_SEG * BASE_W;

   if (BASE_W < 1 || BASE_W > 64) begin : g_bad_base_w
      $error("seg_base_tracker: BASE_W must lie in 1..64");
   end
   if (NUM_SEG > (1 << SEL_W)) begin : g_bad_sel_w
      $error("seg_base_tracker: selector too narrow for segment count");
   end

   logic                enter64;
   logic                leave64;
   logic                gate64;
   logic [NUM_SEG-1:0]  hit_vec;

   seg_mode_ctrl u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .attr_wr_en   (attr_wr_en),
      .attr_wr_long (attr_wr_long),
      .long_active  (long_active),
      .enter64      (enter64),
      .leave64      (leave64),
      .gate64       (gate64)
   );

   for (genvar gi = 0; gi < NUM_SEG; gi++) begin : g_seg
      localparam bit IS_FOLLOW = seg_follows_always(gi);

      assign hit_vec[gi] = base_wr_en && (base_wr_sel == SEL_W'(gi));

      seg_base_slot #(
         .BASE_W (BASE_W),
         .FOLLOW (IS_FOLLOW)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_hit  (hit_vec[gi]),
         .wr_data (base_wr_data),
         .enter64 (enter64),
         .leave64 (leave64),
         .gate64  (gate64),
         .eff_q   (eff_base[gi*BASE_W +: BASE_W])
      );
   end

   assert_one_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   assert_bad_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (base_wr_en && (base_wr_sel >= SEL_W'(NUM_SEG)) && !attr_wr_en)
         |=> $stable(eff_base));

   assert_reset_R7: assert property (@(posedge clk)
      $past(!rst_n) |-> (eff_base == BUS_W'(0)));

endmodule

// File: tb/seg_base_tracker_bench.sv
module seg_base_tracker_bench;

   localparam int BW = 64;
   localparam int NS = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              base_wr_en = 1'b0;
   logic [2:0]        base_wr_sel = '0;
   logic [BW-1:0]     base_wr_data = '0;
   logic              attr_wr_en = 1'b0;
   logic              attr_wr_long = 1'b0;
   logic              long_active = 1'b0;
   logic [NS*BW-1:0]  eff_base;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // Expected state built from the requirements
   logic [BW-1:0] m_prog [NS];
   logic [BW-1:0] m_eff  [NS];
   logic          m_long;

   always #5 clk = ~clk;

   seg_base_tracker #(.BASE_W(BW)) u_seg_base_tracker (
      .clk          (clk),
      .rst_n        (rst_n),
      .base_wr_en   (base_wr_en),
      .base_wr_sel  (base_wr_sel),
      .base_wr_data (base_wr_data),
      .attr_wr_en   (attr_wr_en),
      .attr_wr_long (attr_wr_long),
      .long_active  (long_active),
      .eff_base     (eff_base)
   );

   task automatic check(input string req, input int seg, input logic [BW-1:0] exp);
      logic [BW-1:0] act;
      act = eff_base[seg*BW +: BW];
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s seg%0d actual=%h expected=%h", req, seg, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int k = 0; k < NS; k++) check(req, k, m_eff[k]);
   endtask

   // One cycle of stimulus, applied at a falling edge; the model applies the
   // attribute write first (R8), then the base write.
   task automatic step(input bit bw, input int sel, input logic [BW-1:0] d,
                       input bit aw, input bit al, input bit la);
      base_wr_en   = bw;
      base_wr_sel  = 3'(sel);
      base_wr_data = d;
      attr_wr_en   = aw;
      attr_wr_long = al;
      long_active  = la;
      if (aw) begin
         if (al && !m_long)
            for (int k = 0; k < 4; k++) m_eff[k] = '0;
         else if (!al && m_long)
            for (int k = 0; k < 4; k++) m_eff[k] = m_prog[k];
         m_long = al;
      end
      if (bw && sel < NS) begin
         m_prog[sel] = d;
         if (sel >= 4 || !(la && m_long)) m_eff[sel] = d;
      end
      @(negedge clk);
      base_wr_en = 1'b0;
      attr_wr_en = 1'b0;
   endtask

   task automatic t_reset;
      for (int k = 0; k < NS; k++) begin
         m_prog[k] = '0;
         m_eff[k]  = '0;
      end
      m_long = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      for (int k = 0; k < NS; k++) check("R7", k, '0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_legacy_writes;
      for (int k = 0; k < NS; k++)
         step(1, k, 64'h1000_0000_0000_0000 + 64'(k * 17), 0, 0, 0);
      for (int k = 0; k < 4; k++) check("R2", k, 64'h1000_0000_0000_0000 + 64'(k * 17));
      check("R1", 4, 64'h1000_0000_0000_0044);
      check("R1", 5, 64'h1000_0000_0000_0055);
   endtask

   task automatic t_enter;
      step(0, 0, '0, 0, 0, 1);
      check_all("R10");
      step(0, 0, '0, 1, 1, 1);
      for (int k = 0; k < 4; k++) check("R3", k, '0);
      check("R1", 4, m_eff[4]);
      check("R1", 5, m_eff[5]);
   endtask

   task automatic t_gated;
      step(1, 3, 64'hDEAD_BEEF_0000_0003, 0, 1, 1);
      check("R2", 3, '0);
      step(1, 1, 64'hC0DE_0000_1111_0001, 0, 1, 1);
      check("R2", 1, '0);
      step(1, 4, 64'hFFFF_0000_AAAA_0004, 0, 1, 1);
      check("R1", 4, 64'hFFFF_0000_AAAA_0004);
      step(1, 5, 64'h0123_4567_89AB_CDEF, 0, 1, 1);
      check("R1", 5, 64'h0123_4567_89AB_CDEF);
      step(0, 0, '0, 1, 1, 1);
      check_all("R5");
      step(0, 0, '0, 0, 1, 0);
      check_all("R10");
      step(0, 0, '0, 0, 1, 1);
      check_all("R10");
   endtask

   task automatic t_leave;
      step(0, 0, '0, 1, 0, 1);
      check("R6", 3, 64'hDEAD_BEEF_0000_0003);
      check("R6", 1, 64'hC0DE_0000_1111_0001);
      check("R4", 0, 64'h1000_0000_0000_0000);
      check("R4", 2, 64'h1000_0000_0000_0022);
      check("R1", 4, 64'hFFFF_0000_AAAA_0004);
      step(0, 0, '0, 1, 0, 1);
      check_all("R5");
   endtask

   task automatic t_compat_entry;
      step(0, 0, '0, 1, 1, 0);
      for (int k = 0; k < 4; k++) check("R3", k, '0);
      step(1, 0, 64'h0000_0000_0BAD_F00D, 0, 1, 0);
      check("R2", 0, 64'h0000_0000_0BAD_F00D);
      step(0, 0, '0, 1, 0, 0);
      check_all("R4");
   endtask

   task automatic t_same_cycle;
      step(0, 0, '0, 1, 1, 1);
      step(1, 2, 64'h5555_AAAA_5555_AAAA, 1, 0, 1);
      check("R8", 2, 64'h5555_AAAA_5555_AAAA);
      check("R8", 0, m_eff[0]);
      step(1, 1, 64'h7777_0000_0000_7777, 1, 1, 1);
      check("R8", 1, '0);
      step(0, 0, '0, 1, 0, 1);
      check("R8", 1, 64'h7777_0000_0000_7777);
      step(0, 0, '0, 1, 1, 0);
      step(1, 3, 64'h0000_3333_0000_3333, 1, 0, 0);
      check("R8", 3, 64'h0000_3333_0000_3333);
   endtask

   task automatic t_bad_sel;
      step(1, 6, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0);
      check_all("R9");
      step(1, 7, 64'hEEEE_EEEE_EEEE_EEEE, 0, 0, 0);
      check_all("R9");
      step(0, 0, '0, 1, 1, 1);
      step(0, 0, '0, 1, 0, 1);
      check_all("R9");
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_legacy_writes();
      t_enter();
      t_gated();
      t_leave();
      t_compat_entry();
      t_same_cycle();
      t_bad_sel();
      t_reset();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule